// File: doc/BRIEF.md
# Bus-Idle Soft-Reset Watchdog

This block watches a memory-bus activity strobe and, once the bus has been quiet for longer than a programmed limit, sends a one-cycle soft-reset pulse to two downstream engines: the codec pipe and the embedded microcontroller. The limit is counted in coarse units of `UNIT_CLKS` clocks, 1000 by default. A free-running prescaler turns raw clocks into those units, and a unit counter compares the number of quiet units against the programmed limit.

The limit is a 32-bit value that takes effect on a load strobe. A limit of zero switches the watchdog off. The watchdog is also held off for as long as the mode input selects encoder operation. After it fires once, the watchdog stays quiet until the bus shows activity again. A sticky flag records that a reset has been issued. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `idle_reset_watchdog`

## Requirements
- R1: While reset is active and just after it is released, both reset pulses and the sticky flag are 0. The loaded limit resets to 0.
- R2: Take a nonzero limit T in decoder mode (`mode_enc`=0). Both pulses go high in the cycle that follows T×UNIT_CLKS consecutive idle clock edges, counted after the edge that last sampled `bus_active`=1.
- R3: Each firing drives `rst_pulse_pipe` and `rst_pulse_ucore` high together, for exactly one cycle.
- R4: Any edge that samples `bus_active`=1 restarts the idle count from zero, and no pulse follows that edge.
- R5: While the loaded limit is 0, no pulse is ever produced.
- R6: While `mode_enc`=1 (encoder), no pulse is produced and the count is held at zero. After a return to decoder mode, counting starts afresh and R2 timing applies from the last encoder-mode edge.
- R7: `fired_flag` rises together with the first pulse and stays at 1 until reset.
- R8: A quiet period produces at most one firing. The watchdog re-arms only after an edge samples `bus_active`=1.
- R9: An edge that samples `thr_load`=1 stores `thr_value` as the new limit and restarts the idle count, exactly as bus activity does for R2 timing.
- R10: The count of quiet units never exceeds the loaded limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_active | input | 1 | Memory-bus activity strobe; 1 means activity seen this cycle |
| thr_value | input | THR_W | Idle limit, in units of UNIT_CLKS clocks |
| thr_load | input | 1 | Stores `thr_value` as the limit |
| mode_enc | input | 1 | 1 = encoder operation (watchdog blocked), 0 = decoder |
| rst_pulse_pipe | output | 1 | One-cycle soft reset to the codec pipe |
| rst_pulse_ucore | output | 1 | One-cycle soft reset to the microcontroller |
| fired_flag | output | 1 | Sticky: a soft reset has been issued since reset |

## Verification
The hardest state to reach from the ports is the one just after a firing with no activity since. That state is the only one that shows whether the watchdog re-arms on its own. The bench reaches it by letting a timed run complete, then holding the bus idle for several times the limit while watching for a second pulse, and only then strobing activity for a fresh timed run. The bench uses a 4-clock unit so that full sweeps of the limit, with restarts placed mid-unit and mid-count, stay short.

// File: rtl/wd_pkg.sv
package wd_pkg;
  // Downstream engines that receive the soft reset.
  localparam int unsigned NUM_ENG = 2;
  typedef enum logic [0:0] {
    ENG_PIPE  = 1'b0,
    ENG_UCORE = 1'b1
  } eng_e;
endpackage

// File: rtl/wd_prescaler.sv
// Divides the clock into idle units; emits tick on the last clock of a unit.
module wd_prescaler #(
  parameter int unsigned UNIT_CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(UNIT_CLKS - 1);

  logic [PW-1:0] cnt_q;

  assign tick = !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tick) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wd_unit_counter.sv
// Counts whole idle units since the last clear.
module wd_unit_counter #(
  parameter int unsigned THR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [THR_W-1:0] units
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) units <= '0;
    else if (inc)      units <= units + 1'b1;
  end
endmodule

// File: rtl/wd_fire_ctrl.sv
// Arming state, per-engine pulse registers and sticky flag.
module wd_fire_ctrl
  import wd_pkg::*;
#(
  parameter int unsigned N = NUM_ENG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_active,
  input  logic         fire,
  output logic         armed,
  output logic [N-1:0] pulse,
  output logic         sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n)          armed <= 1'b1;
    else if (bus_active) armed <= 1'b1;
    else if (fire)       armed <= 1'b0;
  end

  for (genvar g = 0; g < N; g++) begin : g_eng
    always_ff @(posedge clk) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sticky <= 1'b0;
    else if (fire) sticky <= 1'b1;
  end
endmodule

// File: rtl/idle_reset_watchdog.sv
module idle_reset_watchdog
  import wd_pkg::*;
#(
  parameter int unsigned UNIT_CLKS = 1000,
  parameter int unsigned THR_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_active,
  input  logic [THR_W-1:0] thr_value,
  input  logic             thr_load,
  input  logic             mode_enc,
  output logic             rst_pulse_pipe,
  output logic             rst_pulse_ucore,
  output logic             fired_flag
);
  logic [THR_W-1:0]   thr_q;
  logic [THR_W-1:0]   units;
  logic               armed;
  logic               run_en;
  logic               clr;
  logic               tick;
  logic               fire;
  logic [NUM_ENG-1:0] pulse;

  always_ff @(posedge clk) begin
    if (!rst_n)        thr_q <= '0;
    else if (thr_load) thr_q <= thr_value;
  end

  assign run_en = armed && !mode_enc && (thr_q != '0);
  assign clr    = bus_active || thr_load || !run_en;
  assign fire   = !clr && (units == thr_q);

  wd_prescaler #(.UNIT_CLKS(UNIT_CLKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
  );

  wd_unit_counter #(.THR_W(THR_W)) u_units (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(tick), .units(units)
  );

  wd_fire_ctrl #(.N(NUM_ENG)) u_fire (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .fire(fire),
    .armed(armed), .pulse(pulse), .sticky(fired_flag)
  );

  assign rst_pulse_pipe  = pulse[ENG_PIPE];
  assign rst_pulse_ucore = pulse[ENG_UCORE];
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int unsigned THR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_active,
  input logic             mode_enc,
  input logic             pulse_a,
  input logic             pulse_b,
  input logic             flag,
  input logic [THR_W-1:0] thr_q,
  input logic [THR_W-1:0] units
);
  assert_engines_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_a == pulse_b);
  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_a |=> !pulse_a);
  assert_activity_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |=> !pulse_a);
  assert_zero_limit_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |=> !pulse_a);
  assert_encoder_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_enc |=> !pulse_a);
  assert_flag_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_a |-> flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    units <= thr_q);
endmodule

bind idle_reset_watchdog wd_checker #(.THR_W(THR_W)) u_wd_checker (
  .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .mode_enc(mode_enc),
  .pulse_a(rst_pulse_pipe), .pulse_b(rst_pulse_ucore), .flag(fired_flag),
  .thr_q(thr_q), .units(units)
);

// File: tb/test_idle_reset_watchdog.sv
module test_idle_reset_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int U          = 4;
  localparam int TW         = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_active = 1'b0;
  logic [TW-1:0] thr_value = '0;
  logic          thr_load = 1'b0;
  logic          mode_enc = 1'b0;
  logic          rst_pulse_pipe, rst_pulse_ucore, fired_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_reset_watchdog #(.UNIT_CLKS(U), .THR_W(TW)) i_idle_reset_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .thr_value(thr_value),
    .thr_load(thr_load), .mode_enc(mode_enc), .rst_pulse_pipe(rst_pulse_pipe),
    .rst_pulse_ucore(rst_pulse_ucore), .fired_flag(fired_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk); bus_active = 1'b1;
    @(negedge clk); bus_active = 1'b0;
  endtask

  task automatic load(input int t);
    @(negedge clk); thr_value = TW'(t); thr_load = 1'b1;
    @(negedge clk); thr_load = 1'b0;
  endtask

  // Counts clock edges until a pulse is seen; pulses checked at negedge.
  task automatic measure(input int limit, output int n, output bit both_ok);
    n = 0;
    both_ok = 1'b1;
    while (n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_pulse_pipe != rst_pulse_ucore) both_ok = 1'b0;
      if (rst_pulse_pipe) break;
    end
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_pulse_pipe || rst_pulse_ucore) seen++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n; int seen; bit ok;
    repeat (3) @(negedge clk);
    check(!rst_pulse_pipe && !rst_pulse_ucore && !fired_flag, "R1 during reset", fired_flag, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!rst_pulse_pipe && !rst_pulse_ucore && !fired_flag, "R1 after reset", fired_flag, 0);

    // R5: reset limit is zero -> never fires
    quiet(60, seen);
    check(seen == 0, "R5 zero limit after reset", seen, 0);
    load(0); kick();
    quiet(60, seen);
    check(seen == 0, "R5 zero limit loaded", seen, 0);
    check(!fired_flag, "R7 flag still low", fired_flag, 0);

    // R9/R2 sweep: load then time from the load edge
    for (int t = 1; t <= 6; t++) begin
      kick();
      load(t);
      measure(t*U + 20, n, ok);
      check(n == t*U + 1, "R9 timing from load", n, t*U + 1);
      check(ok, "R3 engines together", 0, 1);
      @(negedge clk);
      check(!rst_pulse_pipe, "R3 single cycle", rst_pulse_pipe, 0);
      check(fired_flag, "R7 flag set", fired_flag, 1);
      // R8: no second firing without activity
      quiet(3*t*U + 5, seen);
      check(seen == 0, "R8 no refire while idle", seen, 0);
      // R2: re-armed by activity
      kick();
      measure(t*U + 20, n, ok);
      check(n == t*U + 1, "R2 timing from activity", n, t*U + 1);
    end

    // R4: activity at every offset inside a count restarts it
    load(3);
    for (int k = 1; k < 3*U; k++) begin
      kick();
      quiet(k, seen);
      check(seen == 0, "R4 no pulse before limit", seen, 0);
      kick();
      measure(3*U + 20, n, ok);
      check(n == 3*U + 1, "R4 restart after activity", n, 3*U + 1);
    end

    // R6: encoder mode blocks; return restarts count
    load(2);
    kick();
    @(negedge clk); mode_enc = 1'b1;
    quiet(40, seen);
    check(seen == 0, "R6 encoder blocked", seen, 0);
    mode_enc = 1'b0;
    measure(2*U + 20, n, ok);
    check(n == 2*U + 1, "R6 timing after return", n, 2*U + 1);

    // R7: flag holds until reset
    kick();
    quiet(5, seen);
    check(fired_flag, "R7 flag holds", fired_flag, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!fired_flag, "R1 flag cleared by reset", fired_flag, 0);
    quiet(40, seen);
    check(seen == 0, "R1 limit back to zero", seen, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule